// File: doc/BRIEF.md
# Bidirectional Twisted-Ring Control-State Sequencer

This block holds the control state of a memory-management controller. The state has two parts. The major field is a 2-bit twisted-ring (Johnson) register with four values. The minor field is a 4-bit twisted-ring register with eight values. A state is written major.minor, with the minor field given by its code value. Each field moves only when its own shift-left or shift-right strobe is asserted.

Each clock edge applies the strobes and registers the decoded view of the new state. The decoded view has one line per major value, one line per minor ring position, and one line per combined major/minor state. A flag is raised when the sequencer sits in one of the two forbidden states, or when a field received conflicting strobes on the previous edge. The logic that decides when to strobe lies outside this block.

Top module: `jseq_state_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes the idle state 0.0. The outputs then read `major_line_o`=0001, `minor_line_o`=00000001 and `state_line_o` with only bit 0 set, with `bad_state_o`=0.
- R2: The minor field takes only the codes 0, 1, 3, 7, 15, 14, 12 and 8, which are ring positions 0 to 7. `minor_line_o[k]` is high for position k, and exactly one minor line is high.
- R3: A minor shift-left alone shifts the field left and feeds the inverted MSB into the LSB. This advances the ring position by one modulo 8 (0, 1, 3, 7, 15, 14, 12, 8, 0).
- R4: A minor shift-right alone shifts the field right and feeds the inverted LSB into the MSB. This moves the ring position back by one modulo 8, so from 0.0 the states run 0.8, 0.12, 0.14, 0.15, 0.7, 0.3, 0.1 and 0.0.
- R5: The major field uses the codes 00, 01, 11, 10, and `major_line_o[v]` is high for numeric value v. A shift-left alone steps the value 0→1→3→2→0, and a shift-right alone steps it the reverse way (for example 3→1 and 0→2).
- R6: A field with neither strobe asserted keeps its value.
- R7: `state_line_o[8*major + minor_position]` is high for the current state, and at most one state line is high.
- R8: States 2.8 and 2.12 (major value 2 with minor position 7 or 6) are forbidden. In these states `bad_state_o` is 1 and `state_line_o` is all zero.
- R9: When both strobes of one field are asserted on the same edge, that field keeps its value and `bad_state_o` is 1 after that edge.
- R10: A major shift and a minor shift on the same edge both take effect on that edge.
- R11: All outputs are registered and show the new state right after the edge that applied the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to state 0.0 |
| maj_shl | input | 1 | Major field shift-left strobe |
| maj_shr | input | 1 | Major field shift-right strobe |
| min_shl | input | 1 | Minor field shift-left strobe |
| min_shr | input | 1 | Minor field shift-right strobe |
| major_line_o | output | 4 | One-hot major value lines, indexed by numeric value |
| minor_line_o | output | 8 | One-hot minor ring-position lines |
| state_line_o | output | 32 | One line per combined state, index 8*major+position |
| bad_state_o | output | 1 | Forbidden state or strobe conflict |

## Verification
A corrupted ring register appears on the outputs immediately after the edge that loaded it, because the decoded lines are registered from the next-state value. The fault shows as a wrong or missing one-hot minor line, or as a combined line at an unexpected index. A wrong feedback inversion therefore shows up within one strobe, as a position jump other than ±1. A broken conflict or forbidden-state rule shows up on `bad_state_o` after the same single edge.

// File: rtl/jseq_pkg.sv
package jseq_pkg;
  // Code held by a w-bit twisted ring at position k (0 <= k < 2w),
  // counting from all-zero in the shift-left direction.
  function automatic logic [31:0] ring_code(input int w, input int k);
    logic [31:0] ones;
    ones = (32'd1 << w) - 32'd1;
    if (k < w) return (32'd1 << k) - 32'd1;
    return ones & ~((32'd1 << (k - w)) - 32'd1);
  endfunction
endpackage

// File: rtl/jring_step.sv
module jring_step #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_l,
  input  logic         step_r,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o,
  output logic         clash_o
);
  always_comb begin
    clash_o = step_l & step_r;
    nxt_o   = q_o;
    if (step_l && !step_r)      nxt_o = {q_o[W-2:0], ~q_o[W-1]};
    else if (step_r && !step_l) nxt_o = {~q_o[0], q_o[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= nxt_o;
  end

  AST_CLASH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (step_l && step_r) |=> (q_o == $past(q_o))); // R9
endmodule

// File: rtl/jring_decode.sv
module jring_decode #(
  parameter int W = 4,
  localparam int N = 2 * W
) (
  input  logic [W-1:0] code_i,
  output logic [N-1:0] line_o,
  output logic         legal_o
);
  import jseq_pkg::*;

  for (genvar k = 0; k < N; k++) begin : g_pos
    localparam logic [31:0] CODE = ring_code(W, k);
    assign line_o[k] = (code_i == CODE[W-1:0]);
  end

  assign legal_o = |line_o;
endmodule

// File: rtl/jseq_state_seq.sv
module jseq_state_seq #(
  parameter int MAJ_W      = 2,
  parameter int MIN_W      = 4,
  parameter int NOGO_MAJ   = 2,
  parameter int NOGO_POS_A = 6,
  parameter int NOGO_POS_B = 7,
  localparam int NMAJ = 1 << MAJ_W,
  localparam int NMIN = 2 * MIN_W,
  localparam int NST  = NMAJ * NMIN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            maj_shl,
  input  logic            maj_shr,
  input  logic            min_shl,
  input  logic            min_shr,
  output logic [NMAJ-1:0] major_line_o,
  output logic [NMIN-1:0] minor_line_o,
  output logic [NST-1:0]  state_line_o,
  output logic            bad_state_o
);
  logic [MAJ_W-1:0] maj_q, maj_nxt;
  logic [MIN_W-1:0] min_q, min_nxt;
  logic             maj_clash, min_clash, min_legal, nogo_nxt, bad_nxt;
  logic [NMAJ-1:0]  maj_dec;
  logic [NMIN-1:0]  min_dec;
  logic [NST-1:0]   st_dec;

  jring_step #(.W(MAJ_W)) u_maj (
    .clk(clk), .rst(rst), .step_l(maj_shl), .step_r(maj_shr),
    .q_o(maj_q), .nxt_o(maj_nxt), .clash_o(maj_clash)
  );

  jring_step #(.W(MIN_W)) u_min (
    .clk(clk), .rst(rst), .step_l(min_shl), .step_r(min_shr),
    .q_o(min_q), .nxt_o(min_nxt), .clash_o(min_clash)
  );

  jring_decode #(.W(MIN_W)) u_mindec (
    .code_i(min_nxt), .line_o(min_dec), .legal_o(min_legal)
  );

  for (genvar v = 0; v < NMAJ; v++) begin : g_maj
    assign maj_dec[v] = (maj_nxt == MAJ_W'(v));
  end

  assign nogo_nxt = maj_dec[NOGO_MAJ] & (min_dec[NOGO_POS_A] | min_dec[NOGO_POS_B]);
  assign bad_nxt  = nogo_nxt | maj_clash | min_clash | ~min_legal;

  for (genvar m = 0; m < NMAJ; m++) begin : g_st_m
    for (genvar p = 0; p < NMIN; p++) begin : g_st_p
      assign st_dec[m*NMIN + p] = maj_dec[m] & min_dec[p] & ~nogo_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      major_line_o <= NMAJ'(1);
      minor_line_o <= NMIN'(1);
      state_line_o <= NST'(1);
      bad_state_o  <= 1'b0;
    end else begin
      major_line_o <= maj_dec;
      minor_line_o <= min_dec;
      state_line_o <= st_dec;
      bad_state_o  <= bad_nxt;
    end
  end

  AST_MIN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(minor_line_o)); // R2
  AST_MIN_LEFT: assert property (@(posedge clk) disable iff (rst)
    (min_shl && !min_shr) |=>
      (minor_line_o == {$past(minor_line_o[NMIN-2:0]), $past(minor_line_o[NMIN-1])})); // R3
  AST_MIN_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (min_shr && !min_shl) |=>
      (minor_line_o == {$past(minor_line_o[0]), $past(minor_line_o[NMIN-1:1])})); // R4
  AST_MAJ_DOWN: assert property (@(posedge clk) disable iff (rst)
    (major_line_o[NMAJ-1] && maj_shr && !maj_shl) |=> major_line_o[1]); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!maj_shl && !maj_shr && !min_shl && !min_shr) |=>
      ($stable(major_line_o) && $stable(minor_line_o))); // R6
  AST_STATE_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(state_line_o)); // R7
  AST_NOGO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (major_line_o[NOGO_MAJ] && (minor_line_o[NOGO_POS_A] || minor_line_o[NOGO_POS_B]))
      |-> (bad_state_o && state_line_o == '0)); // R8
  AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (rst)
    ((min_shl && min_shr) || (maj_shl && maj_shr)) |=> bad_state_o); // R9
  AST_DUAL_MOVE: assert property (@(posedge clk) disable iff (rst)
    ((maj_shl ^ maj_shr) && (min_shl ^ min_shr)) |=>
      (!$stable(major_line_o) && !$stable(minor_line_o))); // R10
endmodule

// File: tb/sim_jseq_state_seq.sv
module sim_jseq_state_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic maj_shl = 0, maj_shr = 0, min_shl = 0, min_shr = 0;
  logic [3:0]  major_line_o;
  logic [7:0]  minor_line_o;
  logic [31:0] state_line_o;
  logic        bad_state_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  jseq_state_seq u0 (
    .clk(clk), .rst(rst), .maj_shl(maj_shl), .maj_shr(maj_shr),
    .min_shl(min_shl), .min_shr(min_shr), .major_line_o(major_line_o),
    .minor_line_o(minor_line_o), .state_line_o(state_line_o),
    .bad_state_o(bad_state_o)
  );

  // {strobes majL,majR,minL,minR ; expected major value ; expected minor position ; expected flag}
  localparam logic [9:0] VEC [32] = '{
    {4'b0001, 2'd0, 3'd7, 1'b0}, {4'b0001, 2'd0, 3'd6, 1'b0},
    {4'b0001, 2'd0, 3'd5, 1'b0}, {4'b0001, 2'd0, 3'd4, 1'b0},
    {4'b0001, 2'd0, 3'd3, 1'b0}, {4'b0001, 2'd0, 3'd2, 1'b0},
    {4'b0001, 2'd0, 3'd1, 1'b0}, {4'b0001, 2'd0, 3'd0, 1'b0},
    {4'b1000, 2'd1, 3'd0, 1'b0}, {4'b0010, 2'd1, 3'd1, 1'b0},
    {4'b0010, 2'd1, 3'd2, 1'b0}, {4'b0010, 2'd1, 3'd3, 1'b0},
    {4'b0010, 2'd1, 3'd4, 1'b0}, {4'b0010, 2'd1, 3'd5, 1'b0},
    {4'b0010, 2'd1, 3'd6, 1'b0}, {4'b0000, 2'd1, 3'd6, 1'b0},
    {4'b1000, 2'd3, 3'd6, 1'b0}, {4'b1000, 2'd2, 3'd6, 1'b1},
    {4'b0010, 2'd2, 3'd7, 1'b1}, {4'b0010, 2'd2, 3'd0, 1'b0},
    {4'b1010, 2'd0, 3'd1, 1'b0}, {4'b0011, 2'd0, 3'd1, 1'b1},
    {4'b1100, 2'd0, 3'd1, 1'b1}, {4'b1000, 2'd1, 3'd1, 1'b0},
    {4'b1000, 2'd3, 3'd1, 1'b0}, {4'b0100, 2'd1, 3'd1, 1'b0},
    {4'b0100, 2'd0, 3'd1, 1'b0}, {4'b0100, 2'd2, 3'd1, 1'b0},
    {4'b0001, 2'd2, 3'd0, 1'b0}, {4'b0101, 2'd3, 3'd7, 1'b0},
    {4'b1111, 2'd3, 3'd7, 1'b1}, {4'b0000, 2'd3, 3'd7, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] s);
    @(negedge clk);
    {maj_shl, maj_shr, min_shl, min_shr} = s;
    @(posedge clk);
    #5;
    {maj_shl, maj_shr, min_shl, min_shr} = 4'b0000;
  endtask

  task automatic check_state(input string tag, input int mj, input int ps, input logic bad);
    logic [31:0] exp_st;
    exp_st = (mj == 2 && ps >= 6) ? 32'd0 : (32'd1 << (mj * 8 + ps));
    chk({tag, " major"}, 64'(major_line_o), 64'(4'd1 << mj));
    chk({tag, " minor"}, 64'(minor_line_o), 64'(8'd1 << ps));
    chk("R2 minor one-hot", 64'($countones(minor_line_o)), 64'd1);
    chk("R7 state line", 64'(state_line_o), 64'(exp_st));
    chk({tag, " flag"}, 64'(bad_state_o), 64'(bad));
  endtask

  initial begin
    string tag;
    repeat (2) @(posedge clk);
    #5;
    check_state("R1 reset", 0, 0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < 32; i++) begin
      logic [3:0] s;
      s = VEC[i][9:6];
      step(s);
      if ((s[3] && s[2]) || (s[1] && s[0]))            tag = "R9 clash";
      else if (VEC[i][0])                              tag = "R8 forbidden";
      else if ((s[3] ^ s[2]) && (s[1] ^ s[0]))         tag = "R10 dual";
      else if (s[1])                                   tag = "R3 minor left";
      else if (s[0])                                   tag = "R4 minor right";
      else if (s[3] || s[2])                           tag = "R5 major";
      else                                             tag = "R6 hold";
      check_state({tag, " R11"}, int'(VEC[i][5:4]), int'(VEC[i][3:1]), VEC[i][0]);
    end

    // Reset from a non-idle state (currently 3.8)
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #5;
    check_state("R1 reset mid-run", 0, 0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // Idle cycles keep the state
    for (int i = 0; i < 3; i++) begin
      step(4'b0000);
      check_state("R6 idle hold", 0, 0, 1'b0);
    end

    // Forbidden state 2.12 entered by a dual move from 3.14
    step(4'b1000); step(4'b1000);            // 0.0 -> 1.0 -> 3.0
    step(4'b0001); step(4'b0001); step(4'b0001); // 3.8, 3.12, 3.14
    check_state("R4 minor right", 3, 5, 1'b0);
    step(4'b1010);                           // major 3->2, minor 14->12
    check_state("R8 forbidden dual", 2, 6, 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule